// File: doc/BRIEF.md
# Multiprocessor Run-Control Register Block

This block sits on a simple single-cycle register bus shared by the processors of a small multiprocessor system. Any processor may use it to learn its own index and the number of processors present, to set the program address and stack address that a processor is given when it starts, and to start, stop or resume the other processors. Every access carries the index of the processor that issued it and a length qualifier that selects a 4-byte or an 8-byte transfer.

Each processor gets a run-enable bit from the block. Starting a processor also raises a one-cycle load pulse on its own line, with the start program address and start stack value on two shared buses. The processor core samples those values on the pulse. Processor 0 comes out of reset running and the others come out stopped, so a single boot processor can bring up the rest.

The register offsets are word indices on `busOffset`. Offset 0 is the identity register, 1 is the count register, 2 is start, 3 is pause, 4 is resume, 5 is the boot program address and 6 is the boot stack address. Offsets 7 to 15 are unimplemented.

Top module: `cpu_run_ctrl`

## Requirements
- R1: A read of offset 0 returns `busReqId`, zero-extended to 64 bits, in the same cycle.
- R2: A read of offset 1 returns NUM_CPUS. A write to offset 1 changes no state and raises no error.
- R3: A write of index k to offset 2, with k below NUM_CPUS, sets `runEn[k]` at that clock edge. In the following cycle `loadPulse[k]` is high and `startPc`/`startSp` carry the stored boot address and stack values. A start index at or above NUM_CPUS changes nothing and gives no pulse.
- R4: `loadPulse` has at most one bit set and a pulse lasts one cycle per start write.
- R5: A write of index k to offset 3 clears every run bit except bit k, which keeps its value. An index at or above NUM_CPUS clears all run bits.
- R6: A write of index v to offset 4 sets `runEn[v]` only when v, taken as an unsigned 64-bit value, is below NUM_CPUS. This means negative values are rejected. Otherwise nothing changes.
- R7: A write with `busLen8`=1 carries all 64 data bits. A write with `busLen8`=0 uses only bits 31:0 and fills bits 63:32 with copies of bit 31. Offsets 5 and 6 store the resulting value and read it back, and index decoding uses the same value.
- R8: After reset only `runEn[0]` is set, `loadPulse` is zero, `errFlag` is low and offsets 5 and 6 read DEF_BOOT_PC and DEF_BOOT_SP.
- R9: Any access to offsets 7 to 15 reads zero and sets `errFlag`. `errFlag` then stays set until reset.
- R10: Reads of offsets 2, 3 and 4 return zero, raise no error and change no run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busOffset | input | 4 | Register word offset |
| busLen8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| busReqId | input | IDX_W | Index of the issuing processor |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Read data, valid during a read access, else zero |
| runEn | output | NUM_CPUS | Per-processor run enable |
| loadPulse | output | NUM_CPUS | One-cycle start pulse per processor |
| startPc | output | 64 | Program address captured at the last start |
| startSp | output | 64 | Stack value captured at the last start |
| errFlag | output | 1 | Sticky unimplemented-offset flag |

## Verification
The assertions assume that `busValid` is a clean one-cycle strobe with a settled offset and length. They also assume that the bus delivers at most one access per cycle, so only one command strobe is active in any cycle. The stimulus uses a single requester task that drives every field at the falling edge and drops `busValid` one cycle later, so no two accesses ever overlap. The index values cover in-range, just-out-of-range and negative cases, in both 4-byte and 8-byte form.

// File: rtl/cpu_run_ctrl_pkg.sv
package cpu_run_ctrl_pkg;

  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_WHO    = 4'd0;
  localparam logic [OFF_W-1:0] OFF_COUNT  = 4'd1;
  localparam logic [OFF_W-1:0] OFF_START  = 4'd2;
  localparam logic [OFF_W-1:0] OFF_HALT   = 4'd3;
  localparam logic [OFF_W-1:0] OFF_RESUME = 4'd4;
  localparam logic [OFF_W-1:0] OFF_BOOTPC = 4'd5;
  localparam logic [OFF_W-1:0] OFF_BOOTSP = 4'd6;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_WHO,
    RD_COUNT,
    RD_BOOTPC,
    RD_BOOTSP
  } rdSel_e;

  typedef struct packed {
    logic   wrStart;
    logic   wrHalt;
    logic   wrResume;
    logic   wrBootPc;
    logic   wrBootSp;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/cpu_run_ctrl_dec.sv
module cpu_run_ctrl_dec
  import cpu_run_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [OFF_W-1:0] busOffset,
  output ctlStrobes_t      strobes,
  output logic             errFlag
);

  logic known;
  logic doWr;
  logic doRd;

  assign doWr = busValid && busWrite;
  assign doRd = busValid && !busWrite;

  always_comb begin
    strobes = '{wrStart: 1'b0, wrHalt: 1'b0, wrResume: 1'b0,
                wrBootPc: 1'b0, wrBootSp: 1'b0, rdSel: RD_ZERO};
    known = 1'b1;
    unique case (busOffset)
      OFF_WHO:    if (doRd) strobes.rdSel = RD_WHO;
      OFF_COUNT:  if (doRd) strobes.rdSel = RD_COUNT;
      OFF_START:  strobes.wrStart  = doWr;
      OFF_HALT:   strobes.wrHalt   = doWr;
      OFF_RESUME: strobes.wrResume = doWr;
      OFF_BOOTPC: begin
        strobes.wrBootPc = doWr;
        if (doRd) strobes.rdSel = RD_BOOTPC;
      end
      OFF_BOOTSP: begin
        strobes.wrBootSp = doWr;
        if (doRd) strobes.rdSel = RD_BOOTSP;
      end
      default:    known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      errFlag <= 1'b0;
    else if (busValid && !known)
      errFlag <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busOffset > OFF_BOOTSP) |=> errFlag); // R9
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrStart, strobes.wrHalt, strobes.wrResume,
              strobes.wrBootPc, strobes.wrBootSp})); // R4

endmodule

// File: rtl/cpu_run_ctrl_dp.sv
module cpu_run_ctrl_dp
  import cpu_run_ctrl_pkg::*;
#(
  parameter int          NUM_CPUS    = 4,
  parameter int          IDX_W       = 2,
  parameter logic [63:0] DEF_BOOT_PC = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [63:0] DEF_BOOT_SP = 64'hFFFF_FFFF_A000_8000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic                busLen8,
  input  logic [IDX_W-1:0]    busReqId,
  input  logic [63:0]         busWdata,
  output logic [63:0]         busRdata,
  output logic [NUM_CPUS-1:0] runEn,
  output logic [NUM_CPUS-1:0] loadPulse,
  output logic [63:0]         startPc,
  output logic [63:0]         startSp
);

  localparam logic [63:0] CPU_COUNT = 64'(NUM_CPUS);

  logic [63:0]      effData;
  logic             idxOk;
  logic [IDX_W-1:0] idx;
  logic [63:0]      bootPc;
  logic [63:0]      bootSp;
  logic             anyStart;

  assign effData  = busLen8 ? busWdata : {{32{busWdata[31]}}, busWdata[31:0]};
  assign idxOk    = effData < CPU_COUNT;
  assign idx      = effData[IDX_W-1:0];
  assign anyStart = strobes.wrStart && idxOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootPc  <= DEF_BOOT_PC;
      bootSp  <= DEF_BOOT_SP;
      startPc <= DEF_BOOT_PC;
      startSp <= DEF_BOOT_SP;
    end else begin
      if (strobes.wrBootPc) bootPc <= effData;
      if (strobes.wrBootSp) bootSp <= effData;
      if (anyStart) begin
        startPc <= bootPc;
        startSp <= bootSp;
      end
    end
  end

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    logic named;
    assign named = idxOk && (32'(idx) == i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runEn[i]     <= (i == 0);
        loadPulse[i] <= 1'b0;
      end else begin
        loadPulse[i] <= strobes.wrStart && named;
        if (strobes.wrStart && named)
          runEn[i] <= 1'b1;
        else if (strobes.wrHalt && !named)
          runEn[i] <= 1'b0;
        else if (strobes.wrResume && named)
          runEn[i] <= 1'b1;
      end
    end

    AST_PULSE_RUNS: assert property (@(posedge clk) disable iff (!rstN)
      loadPulse[i] |-> runEn[i]); // R3
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_WHO:    busRdata = 64'(busReqId);
      RD_COUNT:  busRdata = CPU_COUNT;
      RD_BOOTPC: busRdata = bootPc;
      RD_BOOTSP: busRdata = bootSp;
      default:   busRdata = '0;
    endcase
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadPulse)); // R4
  AST_PULSE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrStart |=> loadPulse == '0); // R4
  AST_HALT_LEAVES_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHalt |=> $countones(runEn) <= 1); // R5
  AST_RESUME_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrResume && !idxOk) |=> $stable(runEn)); // R6

endmodule

// File: rtl/cpu_run_ctrl.sv
module cpu_run_ctrl
  import cpu_run_ctrl_pkg::*;
#(
  parameter int          NUM_CPUS    = 4,
  parameter logic [63:0] DEF_BOOT_PC = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [63:0] DEF_BOOT_SP = 64'hFFFF_FFFF_A000_8000,
  localparam int         IDX_W       = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [OFF_W-1:0]    busOffset,
  input  logic                busLen8,
  input  logic [IDX_W-1:0]    busReqId,
  input  logic [63:0]         busWdata,
  output logic [63:0]         busRdata,
  output logic [NUM_CPUS-1:0] runEn,
  output logic [NUM_CPUS-1:0] loadPulse,
  output logic [63:0]         startPc,
  output logic [63:0]         startSp,
  output logic                errFlag
);

  ctlStrobes_t strobes;

  cpu_run_ctrl_dec u_dec (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busOffset (busOffset),
    .strobes   (strobes),
    .errFlag   (errFlag)
  );

  cpu_run_ctrl_dp #(
    .NUM_CPUS    (NUM_CPUS),
    .IDX_W       (IDX_W),
    .DEF_BOOT_PC (DEF_BOOT_PC),
    .DEF_BOOT_SP (DEF_BOOT_SP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busLen8   (busLen8),
    .busReqId  (busReqId),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .runEn     (runEn),
    .loadPulse (loadPulse),
    .startPc   (startPc),
    .startSp   (startSp)
  );

endmodule

// File: tb/cpu_run_ctrl_test.sv
module cpu_run_ctrl_test;

  localparam int          N      = 4;
  localparam logic [63:0] DEF_PC = 64'hFFFF_FFFF_BFC0_0000;
  localparam logic [63:0] DEF_SP = 64'hFFFF_FFFF_A000_8000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busOffset = '0;
  logic        busLen8 = 1'b1;
  logic [1:0]  busReqId = '0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata;
  logic [N-1:0] runEn;
  logic [N-1:0] loadPulse;
  logic [63:0] startPc;
  logic [63:0] startSp;
  logic        errFlag;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] expRun;
  logic [63:0]  rd;

  always #5 clk = ~clk;

  cpu_run_ctrl #(.NUM_CPUS(N), .DEF_BOOT_PC(DEF_PC), .DEF_BOOT_SP(DEF_SP)) uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busOffset(busOffset), .busLen8(busLen8), .busReqId(busReqId),
    .busWdata(busWdata), .busRdata(busRdata), .runEn(runEn),
    .loadPulse(loadPulse), .startPc(startPc), .startSp(startSp),
    .errFlag(errFlag));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] off, input logic [63:0] data, input logic len8);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busOffset = off; busWdata = data; busLen8 = len8;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] off, input logic [1:0] who, output logic [63:0] val);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busOffset = off; busReqId = who;
    #1 val = busRdata;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  function automatic logic [63:0] sext(input logic [63:0] d, input logic len8);
    return len8 ? d : {{32{d[31]}}, d[31:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 runEn", 64'(runEn), 64'h1);
    chk("R8 loadPulse", 64'(loadPulse), 64'h0);
    chk("R8 errFlag", 64'(errFlag), 64'h0);
    busRd(4'd5, 2'd0, rd); chk("R8 boot pc", rd, DEF_PC);
    busRd(4'd6, 2'd0, rd); chk("R8 boot sp", rd, DEF_SP);
    expRun = 4'b0001;

    // R1 identity sweep
    for (int w = 0; w < N; w++) begin
      busRd(4'd0, 2'(w), rd); chk("R1 identity", rd, 64'(w));
    end

    // R2 count, and write to it has no effect
    busRd(4'd1, 2'd2, rd); chk("R2 count", rd, 64'(N));
    busWr(4'd1, 64'd99, 1'b1);
    busRd(4'd1, 2'd0, rd); chk("R2 count after write", rd, 64'(N));
    chk("R2 no error", 64'(errFlag), 64'h0);
    chk("R2 run unchanged", 64'(runEn), 64'(expRun));

    // R7 length handling on both address registers
    for (int r = 5; r <= 6; r++) begin
      busWr(4'(r), 64'h1234_5678_9ABC_DEF0, 1'b1);
      busRd(4'(r), 2'd0, rd); chk("R7 8-byte", rd, 64'h1234_5678_9ABC_DEF0);
      busWr(4'(r), 64'h0000_0000_8000_1000, 1'b0);
      busRd(4'(r), 2'd0, rd); chk("R7 4-byte negative", rd, 64'hFFFF_FFFF_8000_1000);
      busWr(4'(r), 64'hDEAD_0000_7000_0000, 1'b0);
      busRd(4'(r), 2'd0, rd); chk("R7 4-byte upper ignored", rd, 64'h0000_0000_7000_0000);
    end

    // R3 / R4 start sweep
    for (int k = 0; k < N; k++) begin
      logic [63:0] pcV;
      logic [63:0] spV;
      pcV = 64'h1000 + 64'(k) * 64'h100;
      spV = sext(64'h8000_0000 + 64'(k), 1'b0);
      busWr(4'd5, pcV, 1'b1);
      busWr(4'd6, 64'h8000_0000 + 64'(k), 1'b0);
      busWr(4'd2, 64'(k), k[0]);
      expRun[k] = 1'b1;
      chk("R3 pulse", 64'(loadPulse), 64'(1) << k);
      chk("R3 start pc", startPc, pcV);
      chk("R3 start sp", startSp, spV);
      chk("R3 run set", 64'(runEn), 64'(expRun));
      @(negedge clk);
      chk("R4 pulse one cycle", 64'(loadPulse), 64'h0);
    end
    busWr(4'd6, 64'd0, 1'b1);
    busWr(4'd3, 64'd2, 1'b1); expRun = 4'b0100;
    busWr(4'd2, 64'd4, 1'b1);
    chk("R3 out-of-range start no pulse", 64'(loadPulse), 64'h0);
    chk("R3 out-of-range start no run", 64'(runEn), 64'(expRun));
    busWr(4'd2, 64'hFFFF_FFFF, 1'b0);
    chk("R3 negative start no pulse", 64'(loadPulse), 64'h0);

    // R5 pause sweep over start patterns
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k <= N; k++) begin
        busWr(4'd3, 64'd9, 1'b1);
        for (int b = 0; b < N; b++) if (p[b]) busWr(4'd4, 64'(b), 1'b1);
        busWr(4'd3, 64'(k), 1'b1);
        expRun = (k < N) ? (4'(p) & (4'b1 << k)) : 4'b0;
        chk("R5 pause", 64'(runEn), 64'(expRun));
      end
    end

    // R6 resume sweep, both lengths, including negative
    busWr(4'd3, 64'd8, 1'b1); expRun = '0;
    for (int v = -2; v < 8; v++) begin
      for (int l = 0; l < 2; l++) begin
        logic [63:0] e;
        e = sext(64'(v), 1'(l));
        busWr(4'd3, 64'd8, 1'b1); expRun = '0;
        busWr(4'd4, 64'(v), 1'(l));
        if (e < 64'(N)) expRun[e[1:0]] = 1'b1;
        chk("R6 resume", 64'(runEn), 64'(expRun));
      end
    end

    // R10 command registers read zero, no error, no change
    for (int o = 2; o <= 4; o++) begin
      busRd(4'(o), 2'd1, rd); chk("R10 read zero", rd, 64'h0);
    end
    chk("R10 no error", 64'(errFlag), 64'h0);
    chk("R10 run unchanged", 64'(runEn), 64'(expRun));

    // R9 unimplemented offsets
    for (int o = 7; o < 16; o++) begin
      busRd(4'(o), 2'd0, rd); chk("R9 read zero", rd, 64'h0);
      chk("R9 error set", 64'(errFlag), 64'h1);
    end
    busWr(4'd9, 64'd1, 1'b1);
    chk("R9 write no run change", 64'(runEn), 64'(expRun));
    repeat (5) @(negedge clk);
    chk("R9 error sticky", 64'(errFlag), 64'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule